// File: doc/BRIEF.md
# Banked GPIO and Pin Function Controller

This block owns a set of pads in one power domain and decides, pad by pad, whether a peripheral function or the general-purpose I/O logic drives it. The pads are split into banks of different sizes. Each bank takes a contiguous run of bits in shared 32-bit registers, starting at a configured base bit. Software programs the controller over a simple word-wide register bus with byte strobes. It sets function-group enables, pull bias and GPIO direction and output, and it reads back synchronized pad levels.

Each function group has one enable bit. A group claims a fixed, parameterised set of pads, and one pad may appear in several groups. A pad falls back to GPIO only when every group that lists it is disabled. When several enabled groups claim a pad, the lowest-numbered group wins. As a build option, the pull-enable and pull-direction fields can be placed in one register, with the direction field moved to a higher bit offset.

Top module: `pinmux_gpio_ctrl`

## Requirements
- R1: After reset, every group enable reads 0, the pull-enable and pull-direction words read 0, and the direction word reads 0xFFFFFFFF (all pads inputs). The output word reads 0, and pad_oe, pad_pu and pad_pd are all 0.
- R2: The register word index is bus_addr divided by 4. The map is: group enables at 0x00, pull enable at 0x04, pull direction at 0x08, direction at 0x0C, output value at 0x10 and input value at 0x14. Each set bus_wstrb[b] writes byte b (bits 8b+7..8b); the other bytes keep their value. A read returns the addressed word on bus_rdata one cycle after bus_rd.
- R3: A write updates the register on the clock edge that samples bus_wr. The pad outputs change on the following edge.
- R4: Pad p maps to bit base + (p - first) of its bank. With the default banks, pads 0..4 map to bits 0..4, pads 5..8 to bits 6..9, and pads 9..11 to bits 11..13.
- R5: A GPIO pad drives pad_oe = 1 when its direction bit is 0 and pad_oe = 0 when the bit is 1. Its pad_out follows its output-value bit.
- R6: A pad claimed by an enabled group takes pad_oe and pad_out from that group's fn_oe and fn_out bits (index group*NUM_PADS + pad).
- R7: A pad returns to GPIO control only when every group that contains it is disabled. Disabling one of two enabled groups that both contain it leaves it under group control.
- R8: When several enabled groups contain the same pad, the lowest-numbered group drives it.
- R9: With its pull-enable bit 0, a pad has neither pad_pu nor pad_pd set. With the bit 1, the pull-direction bit selects pull-up (1) or pull-down (0).
- R10: With SHARED_PULL = 1, the pull-direction field of pad p sits in the pull-enable word at bit PULL_SHIFT + (its mapped bit). The word at 0x08 is then unmapped.
- R11: Pad levels pass through two flops before they appear in the input word at their mapped bits. A read sampled at the second clock edge after a pad change still returns the old level; a read one cycle later returns the new one. Writes to the input word have no effect.
- R12: Writes to unmapped or misaligned addresses (bus_addr[1:0] not 0) change no register. Reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wstrb | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| fn_oe | input | NUM_GROUPS*NUM_PADS | Per-group, per-pad output enable from peripherals |
| fn_out | input | NUM_GROUPS*NUM_PADS | Per-group, per-pad output data from peripherals |
| pad_in | input | NUM_PADS | Asynchronous pad levels |
| pad_oe | output | NUM_PADS | Pad output enable |
| pad_out | output | NUM_PADS | Pad output data |
| pad_pu | output | NUM_PADS | Pull-up enable |
| pad_pd | output | NUM_PADS | Pull-down enable |

## Verification
On every cycle, the assertions check four things. Pull-up and pull-down are never set together on a pad. Reads of unmapped addresses return zero. A full-word write to the group-enable register lands one edge later. Whenever no group was enabled, pad_oe follows the direction bits. Only the bench scenarios can show the rest: the bank-to-bit mapping, group priority on a shared pad, fallback to GPIO only after the last claiming group is dropped, the shared-pull layout, byte-strobe merging and the exact two-flop input latency. Each of these depends on chosen register contents and stimulus.

// File: rtl/pinmux_gpio_ctrl.sv
module pinmux_gpio_ctrl #(
  parameter int NUM_PADS   = 12,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_BANKS  = 3,
  parameter int AW         = 8,
  parameter logic [NUM_BANKS*8-1:0] BANK_FIRST = {8'd9, 8'd5, 8'd0},
  parameter logic [NUM_BANKS*8-1:0] BANK_BASE  = {8'd11, 8'd6, 8'd0},
  parameter logic [NUM_GROUPS*NUM_PADS-1:0] GROUP_PADS = {12'hE00, 12'h060, 12'h00E, 12'h003},
  parameter bit SHARED_PULL = 1'b0,
  parameter int PULL_SHIFT  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [AW-1:0]                  bus_addr,
  input  logic                           bus_wr,
  input  logic [3:0]                     bus_wstrb,
  input  logic [31:0]                    bus_wdata,
  input  logic                           bus_rd,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_GROUPS*NUM_PADS-1:0] fn_oe,
  input  logic [NUM_GROUPS*NUM_PADS-1:0] fn_out,
  input  logic [NUM_PADS-1:0]            pad_in,
  output logic [NUM_PADS-1:0]            pad_oe,
  output logic [NUM_PADS-1:0]            pad_out,
  output logic [NUM_PADS-1:0]            pad_pu,
  output logic [NUM_PADS-1:0]            pad_pd
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] W_MUX  = IW'(0);
  localparam logic [IW-1:0] W_PEN  = IW'(1);
  localparam logic [IW-1:0] W_PDIR = IW'(2);
  localparam logic [IW-1:0] W_DIR  = IW'(3);
  localparam logic [IW-1:0] W_OUT  = IW'(4);
  localparam logic [IW-1:0] W_IN   = IW'(5);

  function automatic int pad_bit(input int p);
    int b;
    b = 0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (p >= int'(BANK_FIRST[k*8 +: 8]))
        b = int'(BANK_BASE[k*8 +: 8]) + p - int'(BANK_FIRST[k*8 +: 8]);
    return b;
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] cur, input logic [31:0] wd,
                                              input logic [3:0] st);
    logic [31:0] r;
    r = cur;
    for (int b = 0; b < 4; b++)
      if (st[b]) r[8*b +: 8] = wd[8*b +: 8];
    return r;
  endfunction

  logic [NUM_GROUPS-1:0] mux_q;
  logic [31:0] pen_q, pdir_q, dir_q, out_q;
  logic [NUM_PADS-1:0] sync1_q, sync2_q;

  wire [IW-1:0] widx    = bus_addr[AW-1:2];
  wire          aligned = (bus_addr[1:0] == 2'b00);
  wire [31:0]   mux_wr  = merge_bytes(32'(mux_q), bus_wdata, bus_wstrb);
  wire [31:0]   pdir_src = SHARED_PULL ? (pen_q >> PULL_SHIFT) : pdir_q;
  wire          hit = aligned && (widx <= W_IN) && !(SHARED_PULL && widx == W_PDIR);

  logic [NUM_PADS-1:0] dir_p, out_p, pen_p, pdn_p, gpio_oe;
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int B = pad_bit(p);
    assign dir_p[p] = dir_q[B];
    assign out_p[p] = out_q[B];
    assign pen_p[p] = pen_q[B];
    assign pdn_p[p] = pdir_src[B];
  end
  assign gpio_oe = ~dir_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mux_q  <= '0;
      pen_q  <= '0;
      pdir_q <= '0;
      dir_q  <= '1;
      out_q  <= '0;
    end else if (bus_wr && aligned) begin
      case (widx)
        W_MUX:  mux_q <= mux_wr[NUM_GROUPS-1:0];
        W_PEN:  pen_q <= merge_bytes(pen_q, bus_wdata, bus_wstrb);
        W_PDIR: if (!SHARED_PULL) pdir_q <= merge_bytes(pdir_q, bus_wdata, bus_wstrb);
        W_DIR:  dir_q <= merge_bytes(dir_q, bus_wdata, bus_wstrb);
        W_OUT:  out_q <= merge_bytes(out_q, bus_wdata, bus_wstrb);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  logic [31:0] in_word, rd_val;
  always_comb begin
    in_word = '0;
    for (int p = 0; p < NUM_PADS; p++) in_word[pad_bit(p)] = sync2_q[p];
  end

  always_comb begin
    rd_val = '0;
    if (aligned)
      case (widx)
        W_MUX:  rd_val = 32'(mux_q);
        W_PEN:  rd_val = pen_q;
        W_PDIR: rd_val = SHARED_PULL ? '0 : pdir_q;
        W_DIR:  rd_val = dir_q;
        W_OUT:  rd_val = out_q;
        W_IN:   rd_val = in_word;
        default: rd_val = '0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  logic [NUM_PADS-1:0] nxt_oe, nxt_out;
  always_comb begin
    nxt_oe  = gpio_oe;
    nxt_out = out_p;
    for (int p = 0; p < NUM_PADS; p++)
      for (int g = NUM_GROUPS - 1; g >= 0; g--)
        if (mux_q[g] && GROUP_PADS[g*NUM_PADS + p]) begin
          nxt_oe[p]  = fn_oe[g*NUM_PADS + p];
          nxt_out[p] = fn_out[g*NUM_PADS + p];
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_oe  <= '0;
      pad_out <= '0;
      pad_pu  <= '0;
      pad_pd  <= '0;
    end else begin
      pad_oe  <= nxt_oe;
      pad_out <= nxt_out;
      pad_pu  <= pen_p & pdn_p;
      pad_pd  <= pen_p & ~pdn_p;
    end
  end

  p_pull_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == 32'd0));

  p_mux_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wstrb == 4'hF) |=> (mux_q == $past(bus_wdata[NUM_GROUPS-1:0])));

  p_gpio_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mux_q) == '0) |-> (pad_oe == $past(gpio_oe)));
endmodule

// File: tb/pinmux_gpio_ctrl_tb.sv
`timescale 1ns/1ps
module pinmux_gpio_ctrl_tb;
  localparam int NP = 12;
  localparam int NG = 4;
  localparam logic [NG*NP-1:0] GMASK = {12'hE00, 12'h060, 12'h00E, 12'h003};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_m, rdata_s;
  logic [NG*NP-1:0] fn_oe  = {12'hFFF, 12'hFFF, 12'h000, 12'hFFF};
  logic [NG*NP-1:0] fn_out = {12'hFFF, 12'h0A0, 12'hFFF, 12'h555};
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] oe_m, out_m, pu_m, pd_m, oe_s, out_s, pu_s, pd_s;

  pinmux_gpio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wstrb(bus_wstrb),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_m), .fn_oe(fn_oe), .fn_out(fn_out),
    .pad_in(pad_in), .pad_oe(oe_m), .pad_out(out_m), .pad_pu(pu_m), .pad_pd(pd_m));

  pinmux_gpio_ctrl #(.SHARED_PULL(1'b1)) u_dut_sh (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wstrb(bus_wstrb),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_s), .fn_oe(fn_oe), .fn_out(fn_out),
    .pad_in(pad_in), .pad_oe(oe_s), .pad_out(out_s), .pad_pu(pu_s), .pad_pd(pd_s));

  int checks = 0, errors = 0;
  logic [31:0] mm [0:4];
  logic [31:0] ms [0:4];
  logic [31:0] in_vis = '0;
  logic [31:0] q_exp_m[$], q_exp_s[$];
  string q_tag[$];
  logic rd_seen = 1'b0;
  logic [NP-1:0] saved;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bitof(input int p);
    if (p >= 9) return 11 + p - 9;
    if (p >= 5) return 6 + p - 5;
    return p;
  endfunction

  function automatic logic [31:0] map_in(input logic [NP-1:0] v);
    logic [31:0] r = '0;
    for (int p = 0; p < NP; p++) r[bitof(p)] = v[p];
    return r;
  endfunction

  function automatic logic [31:0] model_rd(input bit sh, input logic [7:0] a);
    int idx = int'(a[7:2]);
    if (a[1:0] != 2'b00 || idx > 5 || (sh && idx == 2)) return 32'd0;
    if (idx == 5) return in_vis;
    return sh ? ms[idx] : mm[idx];
  endfunction

  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && q_tag.size() > 0) begin
      string t;
      logic [31:0] em, es;
      t = q_tag.pop_front();
      em = q_exp_m.pop_front();
      es = q_exp_s.pop_front();
      chk({t, " main"}, rdata_m, em);
      chk({t, " shared"}, rdata_s, es);
    end
  end

  task automatic do_read(input logic [7:0] a, input string tag);
    q_exp_m.push_back(model_rd(1'b0, a));
    q_exp_s.push_back(model_rd(1'b1, a));
    q_tag.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] st);
    int idx = int'(a[7:2]);
    if (a[1:0] == 2'b00 && idx < 5) begin
      for (int b = 0; b < 4; b++)
        if (st[b]) begin
          mm[idx][8*b +: 8] = d[8*b +: 8];
          if (idx != 2) ms[idx][8*b +: 8] = d[8*b +: 8];
        end
      mm[0] &= 32'hF; ms[0] &= 32'hF;
    end
    bus_addr = a; bus_wdata = d; bus_wstrb = st; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic exp_pads(input bit sh, output logic [NP-1:0] oe, output logic [NP-1:0] out,
                          output logic [NP-1:0] pu, output logic [NP-1:0] pd);
    for (int p = 0; p < NP; p++) begin
      int own = -1;
      int b = bitof(p);
      logic en, up;
      for (int g = NG - 1; g >= 0; g--)
        if (mm[0][g] && GMASK[g*NP + p]) own = g;
      if (own >= 0) begin
        oe[p] = fn_oe[own*NP + p]; out[p] = fn_out[own*NP + p];
      end else begin
        oe[p] = ~mm[3][b]; out[p] = mm[4][b];
      end
      en = sh ? ms[1][b] : mm[1][b];
      up = sh ? ms[1][16 + b] : mm[2][b];
      pu[p] = en & up;
      pd[p] = en & ~up;
    end
  endtask

  task automatic check_pads(input string tag);
    logic [NP-1:0] eo, eu, ep, ed, so, su, sp, sd;
    exp_pads(1'b0, eo, eu, ep, ed);
    exp_pads(1'b1, so, su, sp, sd);
    chk({tag, " pad_oe"}, 32'(oe_m), 32'(eo));
    chk({tag, " pad_out"}, 32'(out_m), 32'(eu));
    chk({tag, " pad_pu"}, 32'(pu_m), 32'(ep));
    chk({tag, " pad_pd"}, 32'(pd_m), 32'(ed));
    chk({tag, " shared pad_pu"}, 32'(pu_s), 32'(sp));
    chk({tag, " shared pad_pd"}, 32'(pd_s), 32'(sd));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) begin mm[i] = '0; ms[i] = '0; end
    mm[3] = 32'hFFFF_FFFF; ms[3] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_pads("R1 reset");
    for (int i = 0; i < 6; i++) do_read(8'(4*i), "R1 reset readback");

    // R4 R5: GPIO outputs on pads 1,2,7,11
    do_write(8'h0C, ~32'h0000_2106, 4'hF);
    do_write(8'h10, 32'h0000_2006, 4'hF);
    @(negedge clk);
    check_pads("R4 R5 gpio drive");

    // R3 latency: register at first edge, pad one edge later
    saved = out_m;
    do_write(8'h10, 32'h0000_2106, 4'hF);
    chk("R3 pad before update", 32'(out_m), 32'(saved));
    do_read(8'h10, "R3 register after one edge");
    check_pads("R3 pad after second edge");

    // R2 byte strobe
    do_write(8'h10, 32'hFFFF_FFFF, 4'b0010);
    do_read(8'h10, "R2 byte strobe merge");
    check_pads("R2 R4 byte strobe pads");
    do_write(8'h10, 32'h0000_2106, 4'hF);

    // R6 group ownership
    do_write(8'h00, 32'h4, 4'hF);
    @(negedge clk);
    check_pads("R6 group 2 owns pads 5 6");

    // R8 priority on pad 1
    do_write(8'h00, 32'h3, 4'hF);
    @(negedge clk);
    check_pads("R8 lowest group wins");
    chk("R8 pad1 oe from group 0", 32'(oe_m[1]), 32'd1);
    chk("R8 pad1 out from group 0", 32'(out_m[1]), 32'd0);

    // R7 fallback only when all claiming groups off
    do_write(8'h00, 32'h2, 4'hF);
    @(negedge clk);
    chk("R7 pad1 still group-owned", 32'(oe_m[1]), 32'd0);
    do_write(8'h00, 32'h0, 4'hF);
    @(negedge clk);
    chk("R7 pad1 back to gpio oe", 32'(oe_m[1]), 32'd1);
    chk("R7 pad1 back to gpio out", 32'(out_m[1]), 32'd1);
    check_pads("R7 all groups off");

    // R9 pulls, R10 shared layout
    do_write(8'h04, 32'h0000_0841, 4'hF);
    do_write(8'h08, 32'h0000_0809, 4'hF);
    @(negedge clk);
    check_pads("R9 pull bias");
    do_read(8'h08, "R10 pull dir word");
    do_write(8'h04, 32'h0801_0841, 4'hF);
    @(negedge clk);
    check_pads("R10 shared pull field");
    do_read(8'h04, "R10 pull enable word");

    // R11 input synchronizer
    pad_in = 12'hA5C;
    do_read(8'h14, "R11 input before first flop");
    do_read(8'h14, "R11 input after one flop");
    in_vis = map_in(12'hA5C);
    do_read(8'h14, "R11 input after two flops");
    do_write(8'h14, 32'hFFFF_FFFF, 4'hF);
    do_read(8'h14, "R11 input write ignored");

    // R12 unmapped and misaligned
    do_write(8'h18, 32'hFFFF_FFFF, 4'hF);
    do_write(8'h11, 32'h0000_0000, 4'hF);
    do_read(8'h10, "R12 misaligned write ignored");
    do_read(8'h18, "R12 unmapped read");
    do_read(8'hFC, "R12 high unmapped read");
    do_read(8'h12, "R12 misaligned read");
    @(negedge clk);
    check_pads("R12 pads unchanged");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule